// File: doc/BRIEF.md
# PCIe Root-Port Power-Up Reset Sequencer

This block steps a PCIe root-port controller and its PHYs from a cold, fully reset condition to the point where link training may begin. A start request begins the sequence. The block holds both the slot-side card reset and the controller reset low and raises the slot power enable. It then waits a parameterised number of clock cycles, which stands for the 100 ms card-reset hold time. After the wait it releases the controller reset and then the card reset.

Next it enables the auxiliary clock and holds the PHY in reset. It releases the power-up reset and hands per-lane PHY register programming to an external write master through a request/done handshake. When the write master reports done, the block switches the auxiliary clock off, drops the PHY hold and switches the clock back on. It then writes the root-complex value into the device-type field and gives a one-cycle ready pulse. The ready pulse permits link training.

A shutdown request, accepted in any state, puts the block back into its fully reset idle condition. A bootloader that runs after a reboot therefore finds the link down and the resets asserted.

Top module: `pcie_pwrseq`

## Requirements
- R1: While `rst` is high, and in the idle state after it, the outputs `card_rst_n_o`, `ctrl_rst_n_o` and `pwrup_rst_n_o` are 0. The outputs `pwr_en_o`, `aux_clk_en_o`, `hold_phy_rst_o`, `prog_req_o`, `dev_type_we_o`, `busy_o` and `link_ready_o` are also 0, and `dev_type_o` is 0.
- R2: Call the first edge at which `start_i` is sampled high in idle edge 0. `busy_o` rises after edge 0. `pwr_en_o` rises after edge 2. Both resets are still low when `pwr_en_o` rises.
- R3: `ctrl_rst_n_o` rises exactly WAIT_CYCLES cycles after `pwr_en_o` rises. `card_rst_n_o` rises one cycle after that.
- R4: The controller reset is released before the card reset, never in the same cycle and never after it.
- R5: After the card reset is released, the following happens in consecutive cycles: `aux_clk_en_o` rises, then `hold_phy_rst_o` rises, then `pwrup_rst_n_o` rises, then `prog_req_o` rises.
- R6: `prog_req_o` stays high until `prog_done_i` is sampled high. In the cycles after that, `aux_clk_en_o` falls, then `hold_phy_rst_o` falls, then `aux_clk_en_o` rises again.
- R7: One cycle after the clock is re-enabled, `dev_type_we_o` pulses for one cycle. From that cycle on, `dev_type_o` holds 4, the root-complex code. `busy_o` stays high from the cycle after start up to and including the write cycle.
- R8: `link_ready_o` is high for exactly one cycle, the cycle after the device-type write. The outputs then hold steady.
- R9: A shutdown request sampled in any state brings every output back to its R1 value on the next cycle.
- R10: A start request is ignored while the sequence is in progress or complete. The output trace is unchanged.
- R11: A `prog_done_i` pulse outside the programming step has no effect on the output trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| start_i | input | 1 | Begin the power-up sequence (taken in idle only) |
| shutdown_i | input | 1 | Return to the fully reset idle state |
| prog_done_i | input | 1 | PHY write master reports that lane programming is finished |
| card_rst_n_o | output | 1 | Slot-side card reset, active low |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock gate enable |
| hold_phy_rst_o | output | 1 | Hold the PHY in reset during register programming |
| pwrup_rst_n_o | output | 1 | Power-up reset, active low |
| prog_req_o | output | 1 | Request to the PHY write master to run lane programming |
| dev_type_we_o | output | 1 | Write strobe for the device-type field |
| dev_type_o | output | 4 | Device-type value (4 = root complex) |
| busy_o | output | 1 | Sequence in progress |
| link_ready_o | output | 1 | One-cycle pulse permitting link training |

## Verification
The full sequence runs once for each programming-done latency from zero to four cycles. Every output is compared in every cycle against a trace built by arithmetic from the wait length and that latency. This separates an error in the wait count from an off-by-one in the handshake exit.

A shutdown is then injected at every cycle offset of a full sequence. This shows that each state, including the wait and the programming step, returns cleanly to idle.

One run adds a stray done pulse during the wait and stray start requests both in the middle of the sequence and after completion. Any such pulse that reached the state would show up as a changed trace. A mid-sequence reset of the sequencer itself is also applied and checked.

// File: rtl/pcie_pwrseq_pkg.sv
package pcie_pwrseq_pkg;

    localparam int unsigned DEVTYPE_W = 4;
    localparam logic [DEVTYPE_W-1:0] DEVTYPE_ROOT = 4'd4;

    // Ordering matters: output decode uses range comparisons on this enum.
    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CARD_LO,
        ST_CTRL_LO,
        ST_PWR_WAIT,
        ST_CTRL_REL,
        ST_CARD_REL,
        ST_AUX_ON,
        ST_HOLD,
        ST_PWRUP_REL,
        ST_PROG,
        ST_AUX_OFF,
        ST_HOLD_CLR,
        ST_AUX_ON2,
        ST_DEVTYPE,
        ST_READY,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic                 card_rst_n;
        logic                 ctrl_rst_n;
        logic                 pwr_en;
        logic                 aux_clk_en;
        logic                 hold_phy_rst;
        logic                 pwrup_rst_n;
        logic                 prog_req;
        logic                 dev_type_we;
        logic [DEVTYPE_W-1:0] dev_type;
        logic                 busy;
        logic                 link_ready;
    } seq_out_t;

    function automatic logic in_span(seq_state_e s, seq_state_e lo, seq_state_e hi);
        return (s >= lo) && (s <= hi);
    endfunction

endpackage

// File: rtl/pwrseq_wait_timer.sv
module pwrseq_wait_timer #(
    parameter int unsigned CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: count never leaves the window it was loaded with
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_VAL);

    // R3: a reload always starts a full window
    p_load_full_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pcie_pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       shutdown,
    input  logic       prog_done,
    input  logic       wait_expired,
    output seq_state_e state,
    output logic       timer_load,
    output logic       timer_tick
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_CARD_LO;
            ST_CARD_LO:   state_d = ST_CTRL_LO;
            ST_CTRL_LO:   state_d = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (wait_expired) state_d = ST_CTRL_REL;
            ST_CTRL_REL:  state_d = ST_CARD_REL;
            ST_CARD_REL:  state_d = ST_AUX_ON;
            ST_AUX_ON:    state_d = ST_HOLD;
            ST_HOLD:      state_d = ST_PWRUP_REL;
            ST_PWRUP_REL: state_d = ST_PROG;
            ST_PROG:      if (prog_done) state_d = ST_AUX_OFF;
            ST_AUX_OFF:   state_d = ST_HOLD_CLR;
            ST_HOLD_CLR:  state_d = ST_AUX_ON2;
            ST_AUX_ON2:   state_d = ST_DEVTYPE;
            ST_DEVTYPE:   state_d = ST_READY;
            ST_READY:     state_d = ST_RUN;
            ST_RUN:       state_d = ST_RUN;
            default:      state_d = ST_IDLE;
        endcase
        if (shutdown) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state      = state_q;
    assign timer_load = (state_q == ST_CTRL_LO);
    assign timer_tick = (state_q == ST_PWR_WAIT);

    // R11: programming step is left only through the done handshake
    p_prog_exit_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG) && !prog_done && !shutdown |=> (state_q == ST_PROG));

    // R10: a running sequence is not restarted by start
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) && !shutdown |=> (state_q == ST_RUN));

endmodule

// File: rtl/pwrseq_outdec.sv
module pwrseq_outdec
    import pcie_pwrseq_pkg::*;
(
    input  seq_state_e state,
    output seq_out_t   outs
);
    always_comb begin
        outs              = '0;
        outs.card_rst_n   = (state >= ST_CARD_REL);
        outs.ctrl_rst_n   = (state >= ST_CTRL_REL);
        outs.pwr_en       = (state >= ST_PWR_WAIT);
        outs.aux_clk_en   = in_span(state, ST_AUX_ON, ST_PROG) || (state >= ST_AUX_ON2);
        outs.hold_phy_rst = in_span(state, ST_HOLD, ST_AUX_OFF);
        outs.pwrup_rst_n  = (state >= ST_PWRUP_REL);
        outs.prog_req     = (state == ST_PROG);
        outs.dev_type_we  = (state == ST_DEVTYPE);
        outs.dev_type     = (state >= ST_DEVTYPE) ? DEVTYPE_ROOT : '0;
        outs.busy         = in_span(state, ST_CARD_LO, ST_DEVTYPE);
        outs.link_ready   = (state == ST_READY);
    end
endmodule

// File: rtl/pcie_pwrseq.sv
module pcie_pwrseq
    import pcie_pwrseq_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 20_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 shutdown_i,
    input  logic                 prog_done_i,
    output logic                 card_rst_n_o,
    output logic                 ctrl_rst_n_o,
    output logic                 pwr_en_o,
    output logic                 aux_clk_en_o,
    output logic                 hold_phy_rst_o,
    output logic                 pwrup_rst_n_o,
    output logic                 prog_req_o,
    output logic                 dev_type_we_o,
    output logic [DEVTYPE_W-1:0] dev_type_o,
    output logic                 busy_o,
    output logic                 link_ready_o
);
    seq_state_e state;
    seq_out_t   outs;
    logic       timer_load, timer_tick, wait_expired;

    pwrseq_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .tick    (timer_tick),
        .expired (wait_expired)
    );

    pwrseq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start_i),
        .shutdown     (shutdown_i),
        .prog_done    (prog_done_i),
        .wait_expired (wait_expired),
        .state        (state),
        .timer_load   (timer_load),
        .timer_tick   (timer_tick)
    );

    pwrseq_outdec u_dec (
        .state (state),
        .outs  (outs)
    );

    assign card_rst_n_o   = outs.card_rst_n;
    assign ctrl_rst_n_o   = outs.ctrl_rst_n;
    assign pwr_en_o       = outs.pwr_en;
    assign aux_clk_en_o   = outs.aux_clk_en;
    assign hold_phy_rst_o = outs.hold_phy_rst;
    assign pwrup_rst_n_o  = outs.pwrup_rst_n;
    assign prog_req_o     = outs.prog_req;
    assign dev_type_we_o  = outs.dev_type_we;
    assign dev_type_o     = outs.dev_type;
    assign busy_o         = outs.busy;
    assign link_ready_o   = outs.link_ready;

    // R3: power is on whenever the controller reset is released
    p_pwr_before_rel_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_rst_n_o) |-> pwr_en_o);

    // R4: card reset only released after the controller reset
    p_card_after_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(card_rst_n_o) |-> $past(ctrl_rst_n_o));

    // R5: PHY held and clocked when power-up reset is released
    p_hold_before_pwrup_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pwrup_rst_n_o) |-> (hold_phy_rst_o && aux_clk_en_o));

    // R6: hold is dropped only with the auxiliary clock gated
    p_hold_clr_gated_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_phy_rst_o) |-> !aux_clk_en_o);

    // R6: request persists until done
    p_prog_hold_r6: assert property (@(posedge clk) disable iff (rst)
        prog_req_o && !prog_done_i && !shutdown_i |=> prog_req_o);

    // R7: busy begins only on a start request
    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R8: ready follows the device-type write and lasts one cycle
    p_ready_after_we_r8: assert property (@(posedge clk) disable iff (rst)
        link_ready_o |-> $past(dev_type_we_o));
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        link_ready_o |=> !link_ready_o);

    // R9: shutdown asserts both resets on the next cycle
    p_shutdown_r9: assert property (@(posedge clk) disable iff (rst)
        shutdown_i |=> (!card_rst_n_o && !ctrl_rst_n_o && !pwr_en_o));

endmodule

// File: tb/pcie_pwrseq_tb.sv
`timescale 1ns/1ps
module pcie_pwrseq_tb;
    localparam int W = 6;
    localparam int P = W + 7;

    logic clk = 1'b0;
    logic rst, start_i, shutdown_i, prog_done_i;
    logic card_rst_n_o, ctrl_rst_n_o, pwr_en_o, aux_clk_en_o, hold_phy_rst_o;
    logic pwrup_rst_n_o, prog_req_o, dev_type_we_o, busy_o, link_ready_o;
    logic [3:0] dev_type_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pcie_pwrseq #(.WAIT_CYCLES(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .shutdown_i(shutdown_i),
        .prog_done_i(prog_done_i), .card_rst_n_o(card_rst_n_o),
        .ctrl_rst_n_o(ctrl_rst_n_o), .pwr_en_o(pwr_en_o),
        .aux_clk_en_o(aux_clk_en_o), .hold_phy_rst_o(hold_phy_rst_o),
        .pwrup_rst_n_o(pwrup_rst_n_o), .prog_req_o(prog_req_o),
        .dev_type_we_o(dev_type_we_o), .dev_type_o(dev_type_o),
        .busy_o(busy_o), .link_ready_o(link_ready_o)
    );

    task automatic chk(string tag, int k, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at step %0d: actual %h expected %h", tag, k, act, exp);
        end
    endtask

    task automatic chk_idle(string tag, int k);
        chk({tag, " resets"}, k, {5'b0, card_rst_n_o, ctrl_rst_n_o, pwrup_rst_n_o}, 8'h00);
        chk({tag, " enables"}, k, {4'b0, pwr_en_o, aux_clk_en_o, hold_phy_rst_o, prog_req_o}, 8'h00);
        chk({tag, " status"}, k, {dev_type_o, dev_type_we_o, busy_o, link_ready_o, 1'b0}, 8'h00);
    endtask

    // Expected trace built from step index k and done latency lat
    task automatic chk_step(int k, int lat);
        int a;
        a = P + lat + 1;
        chk("R2 pwr_en", k, {7'b0, pwr_en_o}, {7'b0, (k >= 2)});
        chk("R3 card_rst_n", k, {7'b0, card_rst_n_o}, {7'b0, (k >= W + 3)});
        chk("R4 ctrl_rst_n", k, {7'b0, ctrl_rst_n_o}, {7'b0, (k >= W + 2)});
        chk("R5 aux/hold/pwrup", k, {5'b0, aux_clk_en_o, hold_phy_rst_o, pwrup_rst_n_o},
            {5'b0, ((k >= W + 4) && (k < a)) || (k >= a + 2),
             (k >= W + 5) && (k < a + 1), (k >= W + 6)});
        chk("R6 prog_req", k, {7'b0, prog_req_o}, {7'b0, (k >= P) && (k < a)});
        chk("R7 devtype/busy", k, {2'b0, dev_type_o, dev_type_we_o, busy_o},
            {2'b0, (k >= a + 3) ? 4'd4 : 4'd0, (k == a + 3), (k <= a + 3)});
        chk("R8 link_ready", k, {7'b0, link_ready_o}, {7'b0, (k == a + 4)});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // sd < 0: no shutdown; stray: add spurious done/start pulses (R10, R11)
    task automatic run_seq(int lat, int sd, bit stray);
        int a;
        a = P + lat + 1;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        for (int k = 0; k < a + 8; k++) begin
            if (sd >= 0 && k == sd + 1) begin
                chk_idle("R9 shutdown", k);
                shutdown_i = 1'b0;
                tick();
                chk_idle("R9 stays idle", k + 1);
                break;
            end
            chk_step(k, lat);
            prog_done_i = (k == P + lat) || (stray && k == 3);
            shutdown_i  = (k == sd);
            start_i     = stray && (k == 5 || k == a + 6);
            tick();
        end
        prog_done_i = 1'b0;
        start_i     = 1'b0;
        if (sd < 0) begin
            shutdown_i = 1'b1;
            tick();
            shutdown_i = 1'b0;
            chk_idle("R9 shutdown from run", 0);
        end
        shutdown_i = 1'b0;
        tick();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; shutdown_i = 1'b0; prog_done_i = 1'b0;
        tick(); tick();
        chk_idle("R1 in reset", 0);
        rst = 1'b0;
        tick();
        chk_idle("R1 after reset", 0);

        // done latency sweep
        for (int lat = 0; lat < 5; lat++) run_seq(lat, -1, 1'b0);
        // stray start and done pulses
        run_seq(1, -1, 1'b1);
        // shutdown at every step
        for (int s = 0; s < P + 10; s++) run_seq(2, s, 1'b0);

        // sequencer reset mid-sequence (R1)
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        for (int k = 0; k < W + 5; k++) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_idle("R1 reset mid-sequence", 0);
        tick();
        chk_idle("R1 idle after reset", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule